// File: doc/BRIEF.md
# Sleep-State Wake Policy Controller

This block holds a 16-bit power-management configuration word and the gating logic that decides whether a wake event may pull the system out of a sleep state. Software programs the word over a simple register bus with byte enables. The gating logic takes the present sleep state, the status of a bus power-management event group, a LAN wake status and the group enable. From these it raises a single-cycle wake request toward the power sequencer.

The configuration word sits in a battery-backed reset domain. Only the dedicated `rtc_rst` input loads its default, and ordinary system reset leaves it alone. A strap input selects which of two defaults is loaded. An external lock-down input freezes the stretch-disable field. Two registered side outputs carry configuration to neighbouring units: a MAC power-down-during-wake-on-LAN enable, and a stretch-disable qualifier for the sleep-signal stretching unit.

Top module: `wake_policy_ctrl`

## Requirements
- R1: While `rtc_rst` is high at a clock edge, the word loads 16'h0200 when `strap_alt` is 1 and 16'h0000 when it is 0, and `cfg_rdata` shows it in the next cycle.
- R2: System reset `rst` does not change the configuration word. It clears `wake_req`.
- R3: A write with `cfg_be[0]` set updates bits 7:0 and a write with `cfg_be[1]` set updates bits 15:8. `cfg_rdata` always returns all 16 bits.
- R4: While `stretch_lock` is high, writes leave bit 12 unchanged, and the other enabled bits are still written.
- R5: In sleep states S1 (code 1), S3 (code 3) and S4 (code 4), a rising bus-event or LAN status wakes the system exactly when `pme_grp_en` is 1. Bits 15 and 13 have no effect in these states.
- R6: In S5 (code 5) with bit 15 clear, a rising bus-event or LAN status wakes the system when `pme_grp_en` is 1.
- R7: In S5 with bit 15 set, the bus-event status never wakes, whatever the value of `pme_grp_en`.
- R8: In S5 with bit 13 (LAN override) set, a rising LAN status wakes the system even with `pme_grp_en` at 0 and even with bit 15 set.
- R9: With `pme_grp_en` at 0 and bit 13 at 0, no status produces a wake in any state.
- R10: `wake_req` is high for exactly one cycle. It rises in the cycle after the first clock edge that sees the qualifying condition. It never asserts while `sleep_state` is S0 (code 0).
- R11: `mac_pd_wol_en` equals the inverse of bit 14, one cycle after the word changes.
- R12: `stretch_dis` equals bit 12 AND `g3_exit`, registered with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rtc_rst | input | 1 | Synchronous active-high battery-domain reset of the word |
| strap_alt | input | 1 | Selects the alternate reset default 16'h0200 |
| stretch_lock | input | 1 | Makes bit 12 read-only |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current configuration word |
| sleep_state | input | 3 | 0=S0, 1=S1, 3=S3, 4=S4, 5=S5 |
| pme_grp_sts | input | 1 | Bus event group wake status |
| lan_wake_sts | input | 1 | Integrated LAN wake status |
| pme_grp_en | input | 1 | Group wake enable |
| g3_exit | input | 1 | Coming out of mechanical-off flag |
| wake_req | output | 1 | One-cycle wake request |
| mac_pd_wol_en | output | 1 | MAC power-down during wake-on-LAN allowed |
| stretch_dis | output | 1 | Stretch-disable qualifier |

## Verification
A write or a reset becomes visible on `cfg_rdata` at the first clock edge that takes it. `mac_pd_wol_en` and `stretch_dis` follow one edge later. The bench therefore samples them at the falling edge after that second edge. For a wake request, the status is raised at a falling edge. `wake_req` is checked at the next falling edge, where it must be high when the trial qualifies. It is checked again one cycle later, where it must be low. Each trial first holds its status low for two cycles so that no earlier rise carries over.

// File: rtl/wake_policy_pkg.sv
package wake_policy_pkg;
  localparam int CFG_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int BE_W       = CFG_W / BYTE_W;
  localparam int BIT_S5_DIS = 15;
  localparam int BIT_MAC_ON = 14;
  localparam int BIT_WOL_OV = 13;
  localparam int BIT_NO_STR = 12;
  localparam logic [CFG_W-1:0] DEF_BASE = 16'h0000;
  localparam logic [CFG_W-1:0] DEF_ALT  = 16'h0200;

  typedef enum logic [2:0] {
    SLP_S0 = 3'd0,
    SLP_S1 = 3'd1,
    SLP_S3 = 3'd3,
    SLP_S4 = 3'd4,
    SLP_S5 = 3'd5
  } slp_state_e;
endpackage

// File: rtl/wp_cfg_reg.sv
module wp_cfg_reg
  import wake_policy_pkg::*;
#(
  parameter int W        = CFG_W,
  parameter int LOCK_BIT = BIT_NO_STR,
  parameter logic [W-1:0] DEF0 = DEF_BASE,
  parameter logic [W-1:0] DEF1 = DEF_ALT
) (
  input  logic                  clk,
  input  logic                  rtc_rst,
  input  logic                  strap_alt,
  input  logic                  lock,
  input  logic                  wr,
  input  logic [W/BYTE_W-1:0]   be,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          q
);
  localparam int NB = W / BYTE_W;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    for (int b = 0; b < NB; b++) begin
      if (wr && be[b]) nxt[b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
    end
    if (lock) nxt[LOCK_BIT] = q[LOCK_BIT];
  end

  always_ff @(posedge clk) begin
    if (rtc_rst) q <= strap_alt ? DEF1 : DEF0;
    else         q <= nxt;
  end
endmodule

// File: rtl/wp_wake_gate.sv
module wp_wake_gate
  import wake_policy_pkg::*;
#(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] state,
  input  logic            pme_sts,
  input  logic            lan_sts,
  input  logic            pme_en,
  input  logic            s5_dis,
  input  logic            wol_ov,
  output logic            wake_req
);
  logic in_light, in_s5, any_src, qual, qual_q;

  always_comb begin
    in_light = (state == SLP_S1) || (state == SLP_S3) || (state == SLP_S4);
    in_s5    = (state == SLP_S5);
    any_src  = pme_sts | lan_sts;
    qual     = (in_light & pme_en & any_src)
             | (in_s5 & ((~s5_dis & pme_en & any_src) | (wol_ov & lan_sts)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q   <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      qual_q   <= qual;
      wake_req <= qual & ~qual_q;
    end
  end
endmodule

// File: rtl/wp_side_outs.sv
module wp_side_outs (
  input  logic clk,
  input  logic rst,
  input  logic mac_keep_on,
  input  logic no_stretch,
  input  logic g3_exit,
  output logic mac_pd_wol_en,
  output logic stretch_dis
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mac_pd_wol_en <= 1'b0;
      stretch_dis   <= 1'b0;
    end else begin
      mac_pd_wol_en <= ~mac_keep_on;
      stretch_dis   <= no_stretch & g3_exit;
    end
  end
endmodule

// File: rtl/wake_policy_ctrl.sv
module wake_policy_ctrl
  import wake_policy_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rtc_rst,
  input  logic        strap_alt,
  input  logic        stretch_lock,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic [2:0]  sleep_state,
  input  logic        pme_grp_sts,
  input  logic        lan_wake_sts,
  input  logic        pme_grp_en,
  input  logic        g3_exit,
  output logic        wake_req,
  output logic        mac_pd_wol_en,
  output logic        stretch_dis
);
  logic [CFG_W-1:0] cfg_q;

  wp_cfg_reg #(.W(CFG_W), .LOCK_BIT(BIT_NO_STR)) u_reg (
    .clk(clk), .rtc_rst(rtc_rst), .strap_alt(strap_alt), .lock(stretch_lock),
    .wr(cfg_wr), .be(cfg_be), .wdata(cfg_wdata), .q(cfg_q)
  );

  wp_wake_gate #(.ST_W(3)) u_gate (
    .clk(clk), .rst(rst), .state(sleep_state), .pme_sts(pme_grp_sts),
    .lan_sts(lan_wake_sts), .pme_en(pme_grp_en), .s5_dis(cfg_q[BIT_S5_DIS]),
    .wol_ov(cfg_q[BIT_WOL_OV]), .wake_req(wake_req)
  );

  wp_side_outs u_side (
    .clk(clk), .rst(rst), .mac_keep_on(cfg_q[BIT_MAC_ON]),
    .no_stretch(cfg_q[BIT_NO_STR]), .g3_exit(g3_exit),
    .mac_pd_wol_en(mac_pd_wol_en), .stretch_dis(stretch_dis)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/wake_policy_checker.sv
module wake_policy_checker (
  input logic        clk,
  input logic        rst,
  input logic        rtc_rst,
  input logic        strap_alt,
  input logic        stretch_lock,
  input logic [15:0] cfg_rdata,
  input logic [2:0]  sleep_state,
  input logic        pme_grp_en,
  input logic        g3_exit,
  input logic        wake_req,
  input logic        mac_pd_wol_en,
  input logic        stretch_dis
);
  p_rtc_default_r1: assert property (@(posedge clk) disable iff (rst)
    rtc_rst |=> cfg_rdata == ($past(strap_alt) ? 16'h0200 : 16'h0000));

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (stretch_lock && !rtc_rst) |=> cfg_rdata[12] == $past(cfg_rdata[12]));

  p_no_enable_r9: assert property (@(posedge clk) disable iff (rst)
    (!pme_grp_en && !cfg_rdata[13]) |=> !wake_req);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  p_s0_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (sleep_state == 3'd0) |=> !wake_req);

  p_mac_follow_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mac_pd_wol_en == !$past(cfg_rdata[14]));

  p_stretch_follow_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stretch_dis == ($past(cfg_rdata[12]) && $past(g3_exit)));
endmodule

bind wake_policy_ctrl wake_policy_checker u_chk (
  .clk(clk), .rst(rst), .rtc_rst(rtc_rst), .strap_alt(strap_alt),
  .stretch_lock(stretch_lock), .cfg_rdata(cfg_rdata), .sleep_state(sleep_state),
  .pme_grp_en(pme_grp_en), .g3_exit(g3_exit), .wake_req(wake_req),
  .mac_pd_wol_en(mac_pd_wol_en), .stretch_dis(stretch_dis)
);

// File: tb/wake_policy_ctrl_tb.sv
module wake_policy_ctrl_tb;
  logic clk = 1'b0;
  logic rst, rtc_rst, strap_alt, stretch_lock, cfg_wr;
  logic [1:0] cfg_be;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [2:0] sleep_state;
  logic pme_grp_sts, lan_wake_sts, pme_grp_en, g3_exit;
  logic wake_req, mac_pd_wol_en, stretch_dis;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wake_policy_ctrl u_dut (
    .clk(clk), .rst(rst), .rtc_rst(rtc_rst), .strap_alt(strap_alt),
    .stretch_lock(stretch_lock), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sleep_state(sleep_state),
    .pme_grp_sts(pme_grp_sts), .lan_wake_sts(lan_wake_sts),
    .pme_grp_en(pme_grp_en), .g3_exit(g3_exit), .wake_req(wake_req),
    .mac_pd_wol_en(mac_pd_wol_en), .stretch_dis(stretch_dis)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 2'b00;
  endtask

  task automatic rtc_pulse(logic strap);
    @(negedge clk);
    strap_alt = strap; rtc_rst = 1'b1;
    @(negedge clk);
    rtc_rst = 1'b0;
  endtask

  function automatic bit exp_wake(int st, bit s5d, bit ov, bit en, bit pme, bit lan);
    if (st == 1 || st == 3 || st == 4) return en & (pme | lan);
    if (st == 5) return (!s5d & en & (pme | lan)) | (ov & lan);
    return 1'b0;
  endfunction

  function automatic string wake_tag(int st, bit s5d, bit ov, bit en);
    if (st == 0) return "R10";
    if (!en && !ov) return "R9";
    if (st != 5) return "R5";
    if (ov && !en) return "R8";
    if (s5d) return "R7";
    return "R6";
  endfunction

  task automatic wake_trial(int st, bit s5d, bit ov, bit en, bit pme, bit lan);
    string tag;
    tag = wake_tag(st, s5d, ov, en);
    @(negedge clk);
    sleep_state = 3'(st); pme_grp_en = en; pme_grp_sts = 1'b0; lan_wake_sts = 1'b0;
    repeat (2) @(negedge clk);
    pme_grp_sts = pme; lan_wake_sts = lan;
    @(negedge clk);
    chk(tag, {15'd0, wake_req}, {15'd0, exp_wake(st, s5d, ov, en, pme, lan)});
    @(negedge clk);
    chk("R10", {15'd0, wake_req}, 16'd0);
    pme_grp_sts = 1'b0; lan_wake_sts = 1'b0;
  endtask

  task automatic t_reset_defaults();
    rtc_pulse(1'b1);
    chk("R1", cfg_rdata, 16'h0200);
    rtc_pulse(1'b0);
    chk("R1", cfg_rdata, 16'h0000);
    chk("R2", {15'd0, wake_req}, 16'd0);
  endtask

  task automatic t_sys_reset_keeps();
    wr_cfg(16'hB000, 2'b11);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R2", cfg_rdata, 16'hB000);
    chk("R2", {15'd0, wake_req}, 16'd0);
  endtask

  task automatic t_byte_enables();
    rtc_pulse(1'b0);
    wr_cfg(16'hA5C3, 2'b01);
    chk("R3", cfg_rdata, 16'h00C3);
    wr_cfg(16'h5A11, 2'b10);
    chk("R3", cfg_rdata, 16'h5AC3);
    wr_cfg(16'hFFFF, 2'b00);
    chk("R3", cfg_rdata, 16'h5AC3);
  endtask

  task automatic t_lock();
    wr_cfg(16'hFFFF, 2'b11);
    stretch_lock = 1'b1;
    wr_cfg(16'h0000, 2'b11);
    chk("R4", cfg_rdata, 16'h1000);
    stretch_lock = 1'b0;
    wr_cfg(16'h0000, 2'b11);
    chk("R4", cfg_rdata, 16'h0000);
    stretch_lock = 1'b1;
    wr_cfg(16'h1000, 2'b10);
    chk("R4", cfg_rdata, 16'h0000);
    stretch_lock = 1'b0;
  endtask

  task automatic t_wake_matrix();
    int states[4] = '{1, 3, 4, 5};
    foreach (states[i]) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        wr_cfg({cfg[1], 1'b0, cfg[0], 13'd0}, 2'b11);
        for (int en = 0; en < 2; en++) begin
          for (int src = 1; src < 4; src++) begin
            wake_trial(states[i], cfg[1], cfg[0], en[0], src[0], src[1]);
          end
        end
      end
    end
  endtask

  task automatic t_s0_quiet();
    wr_cfg(16'h2000, 2'b11);
    wake_trial(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    wake_trial(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_mac();
    wr_cfg(16'h4000, 2'b11);
    @(negedge clk);
    chk("R11", {15'd0, mac_pd_wol_en}, 16'd0);
    wr_cfg(16'h0000, 2'b11);
    @(negedge clk);
    chk("R11", {15'd0, mac_pd_wol_en}, 16'd1);
  endtask

  task automatic t_stretch();
    wr_cfg(16'h1000, 2'b11);
    g3_exit = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12", {15'd0, stretch_dis}, 16'd0);
    g3_exit = 1'b1;
    @(negedge clk);
    chk("R12", {15'd0, stretch_dis}, 16'd1);
    wr_cfg(16'h0000, 2'b11);
    @(negedge clk);
    chk("R12", {15'd0, stretch_dis}, 16'd0);
    g3_exit = 1'b0;
  endtask

  initial begin
    rst = 1'b1; rtc_rst = 1'b1; strap_alt = 1'b0; stretch_lock = 1'b0;
    cfg_wr = 1'b0; cfg_be = 2'b00; cfg_wdata = 16'h0;
    sleep_state = 3'd0; pme_grp_sts = 1'b0; lan_wake_sts = 1'b0;
    pme_grp_en = 1'b0; g3_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; rtc_rst = 1'b0;
    t_reset_defaults();
    t_sys_reset_keeps();
    t_byte_enables();
    t_lock();
    t_wake_matrix();
    t_s0_quiet();
    t_mac();
    t_stretch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule